// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counter units. Each unit has a low and a high count byte. A shared mode register and a shared control register set the behaviour of both units. Each unit can count machine-cycle enables (timer) or falling edges on its own external count pin (counter). It can be qualified by an external gate pin. It runs in one of four layouts: a 13-bit counter behind a 5-bit prescaler, a 16-bit counter, an 8-bit counter with reload from the high byte, or a split layout. In the split layout, unit 0's two bytes become two separate 8-bit timers. Unit 1 freezes when it is given that layout.

Software reaches all six registers through a simple register port. Writes land on the next clock edge. Reads are combinational from the address. Each overflow sets a sticky flag for the unit. The interrupt controller clears a flag with an acknowledge pulse. Every overflow of unit 1, and every overflow of unit 0's high byte in the split layout, also produces a one-cycle strobe for a serial baud-rate divider.

Top module: `dual_timer`

## Requirements
- R1: After reset, all six registers read zero, both overflow flags are low and the baud strobe is low.
- R2: Layout 00 counts on a 13-bit value. When the low five bits of the low byte are all ones, an increment clears the low byte and advances the high byte. A wrap of the high byte from FF to 00 sets the unit's flag.
- R3: Layout 01 counts on {high, low} as one 16-bit value. A wrap from FFFF to 0000 sets the unit's flag.
- R4: Layout 10 counts in the low byte only. An increment at FF loads the low byte from the high byte and sets the unit's flag.
- R5: With unit 0 in layout 11, unit 0's low byte counts under unit 0's run, gate and source controls, and its wrap sets flag 0. Unit 0's high byte counts machine-cycle enables under unit 1's run bit and gate, and its wrap sets flag 1.
- R6: Unit 1 in layout 11 holds both of its count bytes.
- R7: A one-cycle pulse on irq_ack[i] clears flag i when no overflow of that flag's source and no control write happens in the same cycle.
- R8: In counter mode, a unit advances by exactly one per high-to-low transition of its count pin. It ignores the machine-cycle enable and rising edges.
- R9: A unit with its gate bit set advances only while its gate pin is high. The run bit must be set in every case.
- R10: An overflow of unit 1, or of unit 0's high byte in layout 11, raises baud_strobe for exactly the one cycle after the counting edge. Overflows of unit 0 in layouts 00 to 10 do not raise it.
- R11: A control-register write in the same cycle as a hardware flag set leaves the flag at the written value.
- R12: Register map by address. 0 is the mode register; its low nibble is unit 0 and its high nibble is unit 1, each nibble laid out {gate, counter-select, layout[1:0]}. 1 is control: bit0 run0, bit1 flag0, bit2 run1, bit3 flag1; the other bits read zero. 2 and 3 are unit 0 low and high. 4 and 5 are unit 1 low and high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Machine-cycle enable for timer mode |
| cnt_pin | input | 2 | External count pins, one per unit |
| gate_pin | input | 2 | External gate pins, one per unit |
| irq_ack | input | 2 | Flag acknowledge pulses from the interrupt controller |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Register read data, combinational from reg_addr |
| ovf_flag | output | 2 | Sticky overflow flags |
| baud_strobe | output | 1 | One-cycle strobe for the serial baud divider |

## Verification
The assertions check several things on every cycle. A control write fixes the flags on the next cycle. An acknowledge clears its flag. A hardware-set flag 1 always comes with the baud strobe. Unit 1 stays frozen in layout 11. A gated-off unit, or a counter-mode unit that sees no falling edge, keeps its count. The arithmetic of each layout can only be shown by the bench's scenarios. This covers the prescaler wrap, the 16-bit carry, the reload value, the split high byte's hand-over to unit 1's controls, and the exact cycle of the strobe. The bench sweeps those scenarios over start values near each wrap point.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      MD_PRE13   = 2'b00,
      MD_WIDE16  = 2'b01,
      MD_RELOAD8 = 2'b10,
      MD_SPLIT   = 2'b11
   } tmr_mode_e;

   localparam int RA_MODE = 0;
   localparam int RA_CTRL = 1;
   localparam int RA_LO0  = 2;
   localparam int RA_HI0  = 3;
   localparam int RA_LO1  = 4;
   localparam int RA_HI1  = 5;

   localparam int CB_RUN0  = 0;
   localparam int CB_FLAG0 = 1;
   localparam int CB_RUN1  = 2;
   localparam int CB_FLAG1 = 3;
endpackage

// File: rtl/tmr_fall_sync.sv
module tmr_fall_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic fall
);
   if (STAGES < 1) begin : g_bad_stages
      $error("tmr_fall_sync: STAGES must be at least 1");
   end

   logic [STAGES:0] sr;

   always_ff @(posedge clk) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-1:0], pin};
   end

   // older sample high, newer sample low
   assign fall = sr[STAGES] & ~sr[STAGES-1];
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
   import tmr_pkg::*;
#(
   parameter int W        = 8,
   parameter int PRESC_W  = 5,
   parameter bit SPLIT_HI = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  tmr_mode_e    mode,
   input  logic         inc,
   input  logic         inc_hi,
   input  logic         wr_lo,
   input  logic         wr_hi,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] lo,
   output logic [W-1:0] hi,
   output logic         ovf,
   output logic         ovf_hi
);
   localparam logic [W-1:0]   ONE_W  = W'(1);
   localparam logic [2*W-1:0] ONE_2W = (2*W)'(1);

   logic [W-1:0] lo_q, hi_q, lo_n, hi_n;
   logic [W-1:0] sp_lo, sp_hi;
   logic         sp_ovf, sp_ovf_hi;

   if (SPLIT_HI) begin : g_split
      always_comb begin
         sp_lo     = lo_q;
         sp_hi     = hi_q;
         sp_ovf    = 1'b0;
         sp_ovf_hi = 1'b0;
         if (inc) begin
            sp_lo  = lo_q + ONE_W;
            sp_ovf = &lo_q;
         end
         if (inc_hi) begin
            sp_hi     = hi_q + ONE_W;
            sp_ovf_hi = &hi_q;
         end
      end
   end else begin : g_hold
      logic unused_inc_hi;
      assign unused_inc_hi = inc_hi;
      assign sp_lo     = lo_q;
      assign sp_hi     = hi_q;
      assign sp_ovf    = 1'b0;
      assign sp_ovf_hi = 1'b0;
   end

   always_comb begin
      lo_n   = lo_q;
      hi_n   = hi_q;
      ovf    = 1'b0;
      ovf_hi = 1'b0;
      unique case (mode)
         MD_PRE13: begin
            if (inc) begin
               if (&lo_q[PRESC_W-1:0]) begin
                  lo_n = '0;
                  hi_n = hi_q + ONE_W;
                  ovf  = &hi_q;
               end else begin
                  lo_n = lo_q + ONE_W;
               end
            end
         end
         MD_WIDE16: begin
            if (inc) begin
               {hi_n, lo_n} = {hi_q, lo_q} + ONE_2W;
               ovf          = &{hi_q, lo_q};
            end
         end
         MD_RELOAD8: begin
            if (inc) begin
               if (&lo_q) begin
                  lo_n = hi_q;
                  ovf  = 1'b1;
               end else begin
                  lo_n = lo_q + ONE_W;
               end
            end
         end
         MD_SPLIT: begin
            lo_n   = sp_lo;
            hi_n   = sp_hi;
            ovf    = sp_ovf;
            ovf_hi = sp_ovf_hi;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         lo_q <= wr_lo ? wdata : lo_n;
         hi_q <= wr_hi ? wdata : hi_n;
      end
   end

   assign lo = lo_q;
   assign hi = hi_q;
endmodule

// File: rtl/dual_timer.sv
module dual_timer
   import tmr_pkg::*;
#(
   parameter int W           = 8,
   parameter int PRESC_W     = 5,
   parameter int SYNC_STAGES = 2,
   parameter int AW          = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [1:0]    cnt_pin,
   input  logic [1:0]    gate_pin,
   input  logic [1:0]    irq_ack,
   input  logic          reg_wr,
   input  logic [AW-1:0] reg_addr,
   input  logic [W-1:0]  reg_wdata,
   output logic [W-1:0]  reg_rdata,
   output logic [1:0]    ovf_flag,
   output logic          baud_strobe
);
   localparam int NUNITS = 2;
   localparam int NIB    = 4;

   if (W < 8) begin : g_bad_w
      $error("dual_timer: W must be at least 8");
   end
   if (PRESC_W < 1 || PRESC_W >= W) begin : g_bad_presc
      $error("dual_timer: PRESC_W must lie in 1..W-1");
   end
   if (AW < 3) begin : g_bad_aw
      $error("dual_timer: AW must be at least 3");
   end

   logic [7:0]        mode_q;
   logic [NUNITS-1:0] run_q, flag_q;
   logic              baud_q;

   logic [NUNITS-1:0] gate_b, ct_b, en, inc, cnt_fall, ovf_main, ovf_hi;
   logic [W-1:0]      cnt_lo [NUNITS];
   logic [W-1:0]      cnt_hi [NUNITS];
   tmr_mode_e         md [NUNITS];

   logic wr_mode, wr_ctrl;
   logic unused_bits;

   assign wr_mode = reg_wr && (reg_addr == AW'(RA_MODE));
   assign wr_ctrl = reg_wr && (reg_addr == AW'(RA_CTRL));

   for (genvar i = 0; i < NUNITS; i++) begin : g_unit
      assign md[i]     = tmr_mode_e'(mode_q[NIB*i +: 2]);
      assign ct_b[i]   = mode_q[NIB*i + 2];
      assign gate_b[i] = mode_q[NIB*i + 3];

      tmr_fall_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .pin  (cnt_pin[i]),
         .fall (cnt_fall[i])
      );

      assign en[i]  = run_q[i] & (~gate_b[i] | gate_pin[i]);
      assign inc[i] = en[i] & (ct_b[i] ? cnt_fall[i] : tick);

      tmr_unit #(
         .W       (W),
         .PRESC_W (PRESC_W),
         .SPLIT_HI(i == 0)
      ) u_unit (
         .clk   (clk),
         .rst_n (rst_n),
         .mode  (md[i]),
         .inc   (inc[i]),
         .inc_hi((i == 0) ? (en[1] & tick) : 1'b0),
         .wr_lo (reg_wr && (reg_addr == AW'(RA_LO0 + 2*i))),
         .wr_hi (reg_wr && (reg_addr == AW'(RA_HI0 + 2*i))),
         .wdata (reg_wdata),
         .lo    (cnt_lo[i]),
         .hi    (cnt_hi[i]),
         .ovf   (ovf_main[i]),
         .ovf_hi(ovf_hi[i])
      );
   end

   assign unused_bits = ovf_hi[1];

   logic split0, set0, set1;
   assign split0 = (md[0] == MD_SPLIT);
   assign set0   = ovf_main[0];
   assign set1   = split0 ? ovf_hi[0] : ovf_main[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
         run_q  <= '0;
         flag_q <= '0;
         baud_q <= 1'b0;
      end else begin
         baud_q <= ovf_main[1] | ovf_hi[0];
         if (wr_mode) mode_q <= reg_wdata[7:0];
         if (wr_ctrl) begin
            run_q  <= {reg_wdata[CB_RUN1],  reg_wdata[CB_RUN0]};
            flag_q <= {reg_wdata[CB_FLAG1], reg_wdata[CB_FLAG0]};
         end else begin
            if (set0)            flag_q[0] <= 1'b1;
            else if (irq_ack[0]) flag_q[0] <= 1'b0;
            if (set1)            flag_q[1] <= 1'b1;
            else if (irq_ack[1]) flag_q[1] <= 1'b0;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         AW'(RA_MODE): reg_rdata[7:0] = mode_q;
         AW'(RA_CTRL): begin
            reg_rdata[CB_RUN0]  = run_q[0];
            reg_rdata[CB_FLAG0] = flag_q[0];
            reg_rdata[CB_RUN1]  = run_q[1];
            reg_rdata[CB_FLAG1] = flag_q[1];
         end
         AW'(RA_LO0): reg_rdata = cnt_lo[0];
         AW'(RA_HI0): reg_rdata = cnt_hi[0];
         AW'(RA_LO1): reg_rdata = cnt_lo[1];
         AW'(RA_HI1): reg_rdata = cnt_hi[1];
         default:     reg_rdata = '0;
      endcase
   end

   assign ovf_flag    = flag_q;
   assign baud_strobe = baud_q;
endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk
   import tmr_pkg::*;
#(
   parameter int W  = 8,
   parameter int AW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_wr,
   input logic [AW-1:0] reg_addr,
   input logic [W-1:0]  reg_wdata,
   input logic [1:0]    irq_ack,
   input logic [1:0]    gate_pin,
   input logic [1:0]    ovf_flag,
   input logic          baud_strobe,
   input logic [7:0]    mode_q,
   input logic [W-1:0]  lo0,
   input logic [W-1:0]  hi0,
   input logic [W-1:0]  lo1,
   input logic [W-1:0]  hi1,
   input logic          fall0,
   input logic          set0
);
   logic ctrl_wr, wr_u0, wr_u1;
   assign ctrl_wr = reg_wr && (reg_addr == AW'(RA_CTRL));
   assign wr_u0   = reg_wr && (reg_addr == AW'(RA_LO0) || reg_addr == AW'(RA_HI0));
   assign wr_u1   = reg_wr && (reg_addr == AW'(RA_LO1) || reg_addr == AW'(RA_HI1));

   // R11
   ctrl_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> ovf_flag == {$past(reg_wdata[CB_FLAG1]), $past(reg_wdata[CB_FLAG0])});

   // R7
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack[0] && !set0 && !ctrl_wr) |=> !ovf_flag[0]);

   // R10
   strobe_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ovf_flag[1]) && !$past(ctrl_wr)) |-> baud_strobe);

   // R6
   unit1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[5:4] == 2'b11 && !wr_u1) |=> ($stable(lo1) && $stable(hi1)));

   // R9
   gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[3] && !gate_pin[0] && mode_q[1:0] != 2'b11 && !wr_u0)
      |=> $stable({hi0, lo0}));

   // R8
   edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2] && !fall0 && mode_q[1:0] != 2'b11 && !wr_u0)
      |=> $stable({hi0, lo0}));
endmodule

bind dual_timer dual_timer_chk #(.W(W), .AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .irq_ack    (irq_ack),
   .gate_pin   (gate_pin),
   .ovf_flag   (ovf_flag),
   .baud_strobe(baud_strobe),
   .mode_q     (mode_q),
   .lo0        (cnt_lo[0]),
   .hi0        (cnt_hi[0]),
   .lo1        (cnt_lo[1]),
   .hi1        (cnt_hi[1]),
   .fall0      (cnt_fall[0]),
   .set0       (ovf_main[0])
);

// File: tb/sim_dual_timer.sv
module sim_dual_timer;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [1:0] cnt_pin = 2'b11;
   logic [1:0] gate_pin = 2'b00;
   logic [1:0] irq_ack = 2'b00;
   logic       reg_wr = 1'b0;
   logic [2:0] reg_addr = 3'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic [1:0] ovf_flag;
   logic       baud_strobe;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   dual_timer u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_pin(cnt_pin),
      .gate_pin(gate_pin), .irq_ack(irq_ack), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ovf_flag(ovf_flag), .baud_strobe(baud_strobe)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a[2:0]; reg_wdata = d[7:0];
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output int v);
      reg_addr = a[2:0];
      #1;
      v = int'(reg_rdata);
   endtask

   task automatic tick_n(input int n);
      if (n > 0) begin
         @(negedge clk);
         tick = 1'b1;
         repeat (n) @(negedge clk);
         tick = 1'b0;
      end
   endtask

   // reference model of layouts 00, 01, 10: {flag, hi, lo}
   function automatic logic [16:0] model(input int m, input logic [7:0] lo_i,
                                         input logic [7:0] hi_i, input int n);
      logic [7:0] lo = lo_i;
      logic [7:0] hi = hi_i;
      logic       f  = 1'b0;
      for (int k = 0; k < n; k++) begin
         case (m)
            0: if (lo[4:0] == 5'h1f) begin
                  lo = 8'h00;
                  if (hi == 8'hff) f = 1'b1;
                  hi = hi + 8'h01;
               end else lo = lo + 8'h01;
            1: begin
                  if ({hi, lo} == 16'hffff) f = 1'b1;
                  {hi, lo} = {hi, lo} + 16'h0001;
               end
            default: if (lo == 8'hff) begin
                  lo = hi; f = 1'b1;
               end else lo = lo + 8'h01;
         endcase
      end
      return {f, hi, lo};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int v;
      logic [16:0] e;
      logic [7:0] st_lo [4] = '{8'h1a, 8'h00, 8'hf0, 8'hfd};
      logic [7:0] st_hi [4] = '{8'hff, 8'h00, 8'hfe, 8'h80};
      int         st_n  [4] = '{10, 37, 300, 5};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 6; a++) begin
         rd(a, v);
         check("R1 register", v, 0);
      end
      check("R1 flags", int'(ovf_flag), 0);
      check("R1 strobe", int'(baud_strobe), 0);

      // R12 register map readback
      wr(0, 8'ha5); rd(0, v); check("R12 mode", v, 8'ha5);
      wr(1, 8'hff); rd(1, v); check("R12 ctrl", v, 8'h0f);
      wr(1, 8'h00);

      // R2 R3 R4 layout sweep over both units
      for (int u = 0; u < 2; u++) begin
         for (int m = 0; m < 3; m++) begin
            for (int c = 0; c < 4; c++) begin
               string req;
               req = (m == 0) ? "R2" : (m == 1) ? "R3" : "R4";
               wr(0, m << (4*u));
               wr(2 + 2*u, st_lo[c]);
               wr(3 + 2*u, st_hi[c]);
               wr(1, (u == 0) ? 8'h01 : 8'h04);
               tick_n(st_n[c]);
               e = model(m, st_lo[c], st_hi[c], st_n[c]);
               rd(2 + 2*u, v); check({req, " low"}, v, int'(e[7:0]));
               rd(3 + 2*u, v); check({req, " high"}, v, int'(e[15:8]));
               check({req, " flag"}, int'(ovf_flag[u]), int'(e[16]));
               wr(1, 8'h00);
            end
         end
      end

      // R8 counter mode: unit 0, layout 01, counter select
      wr(0, 8'h05); wr(2, 0); wr(3, 0); wr(1, 8'h01);
      @(negedge clk); tick = 1'b1;
      for (int p = 0; p < 5; p++) begin
         cnt_pin[0] = 1'b0; repeat (4) @(negedge clk);
         cnt_pin[0] = 1'b1; repeat (4) @(negedge clk);
      end
      tick = 1'b0;
      rd(2, v); check("R8 edge count", v, 5);
      rd(3, v); check("R8 high byte", v, 0);
      wr(1, 8'h00);

      // R9 gate: unit 0, layout 01, gate on
      wr(0, 8'h09); wr(2, 0); wr(3, 0); wr(1, 8'h01);
      gate_pin[0] = 1'b0; tick_n(20);
      rd(2, v); check("R9 gated off", v, 0);
      gate_pin[0] = 1'b1; tick_n(7);
      rd(2, v); check("R9 gated on", v, 7);
      gate_pin[0] = 1'b0;
      wr(1, 8'h00);

      // R5 R6 split layout on both nibbles
      wr(0, 8'h33); wr(2, 8'h10); wr(3, 8'hfe); wr(4, 8'h44); wr(5, 8'h55);
      wr(1, 8'h01); tick_n(9);
      rd(2, v); check("R5 split low", v, 8'h19);
      rd(3, v); check("R5 split high idle", v, 8'hfe);
      wr(1, 8'h04); tick_n(3);
      rd(3, v); check("R5 split high", v, 8'h01);
      rd(2, v); check("R5 split low idle", v, 8'h19);
      check("R5 flag1", int'(ovf_flag[1]), 1);
      check("R5 flag0", int'(ovf_flag[0]), 0);
      rd(4, v); check("R6 unit1 low held", v, 8'h44);
      rd(5, v); check("R6 unit1 high held", v, 8'h55);
      wr(1, 8'h00);

      // R10 strobe from unit 1 reload overflow
      wr(0, 8'h20); wr(4, 8'hfe); wr(5, 8'hf0); wr(1, 8'h04);
      @(negedge clk); tick = 1'b1;
      @(negedge clk); check("R10 no strobe before wrap", int'(baud_strobe), 0);
      @(negedge clk); tick = 1'b0;
      check("R10 strobe", int'(baud_strobe), 1);
      check("R10 flag1", int'(ovf_flag[1]), 1);
      @(negedge clk); check("R10 strobe one cycle", int'(baud_strobe), 0);
      // unit 0 overflow gives no strobe
      wr(0, 8'h02); wr(2, 8'hff); wr(1, 8'h09);
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      check("R10 unit0 no strobe", int'(baud_strobe), 0);
      check("R10 unit0 flag", int'(ovf_flag[0]), 1);

      // R7 acknowledge clears only its flag
      @(negedge clk); irq_ack = 2'b01;
      @(negedge clk); irq_ack = 2'b00;
      check("R7 flag0 cleared", int'(ovf_flag[0]), 0);
      check("R7 flag1 kept", int'(ovf_flag[1]), 1);
      wr(1, 8'h00);

      // R11 control write beats same-cycle overflow
      wr(0, 8'h20); wr(5, 8'h33); wr(4, 8'hff); wr(1, 8'h04);
      @(negedge clk);
      tick = 1'b1; reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h04;
      @(negedge clk);
      tick = 1'b0; reg_wr = 1'b0;
      check("R11 flag1 written", int'(ovf_flag[1]), 0);
      rd(4, v); check("R11 reload happened", v, 8'h33);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule